// File: doc/BRIEF.md
# Periodic Event Timer with Comparator Channel

The block is a fine-grained event timer for a system chip. A free-running main counter counts up by one on each clock while the global run bit is set. A single comparator channel watches that counter. When the counter equals the channel's target value, the channel flags an interrupt. In one-shot operation it fires once. In periodic operation a hidden period register is added to the target on every match, so the next deadline follows at a fixed spacing without software having to step in.

Software reaches every register through a plain 32-bit write-strobe and address bus, with reads returned combinationally. A self-clearing set-value control splits the setup of a periodic timer into two comparator writes. The first write sets the absolute target and the second sets only the period. This lets a periodic timer be started while the main counter holds an arbitrary value. A routing bit, present only when the block is built with that capability, moves the interrupt from the normal channel line onto a separate legacy timer line. The comparison can be narrowed to the low 32 bits for 32-bit operation.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0 except the capability word, and both interrupt lines are low.
- R2: The capability word at address 0 is read-only. Bit 0 is 1 when legacy routing is built in, and bits 15:8 hold the counter width (0x40 by default). Writes to it change nothing.
- R3: With the run bit (address 1, bit 0) set, the main counter rises by exactly one per clock. With it clear, the counter holds its value. The low and high words of the counter read at addresses 3 and 4.
- R4: The channel configuration at address 5 holds these bits: 0 interrupt enable, 1 periodic, 2 set-value, 3 32-bit compare. It reads back as written, except that set-value clears itself.
- R5: A match is the counter equal to the comparator at a clock edge while the run bit is set. In 32-bit compare mode only the low 32 bits take part. The status bit is visible after the matching edge.
- R6: In periodic mode each match adds the period to the comparator. In 32-bit mode the low word wraps modulo 2^32 and the high word is left unchanged. In full-width mode the whole comparator is added, and this happens whether or not the interrupt is enabled.
- R7: When no set-value sequence is pending, a write to address 6 or 7 loads that word of both the comparator and the period.
- R8: When set-value is written as 1 in periodic mode, the next comparator write loads only the comparator and set-value reads 0 afterwards. The comparator write after that loads only the period.
- R9: In one-shot mode (periodic bit 0) a match raises one interrupt and leaves the comparator unchanged.
- R10: The status bit (address 2, bit 0) is set on each match while the interrupt is enabled, and writing 1 clears it. Writing 0 has no effect, and a match in the same cycle as a clear keeps it set. With the enable clear, no status is raised.
- R11: With the legacy bit (address 1, bit 1) set, the status drives the legacy line and not the channel line. The two lines are never high together.
- R12: A register write takes effect at the clock edge on which the strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_chan | output | 1 | Channel interrupt, level |
| irq_legacy | output | 1 | Legacy-routed interrupt, level |

## Verification
A corrupted comparator, period or set-value sequence shows up first as an interrupt on the wrong cycle. The scoreboard predicts the exact edge of every interrupt rising from the counter value at run start, so an error is caught at the first deadline, within one timer period. A bad add or a missed wrap is also exposed at once by reading the comparator back after a known number of matches. Routing faults appear as the wrong line rising on the very next match. A counter that skips or stalls is caught by reading the counter after a counted run window.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CAPS = 3'd0,
      A_GCTL = 3'd1,
      A_GSTS = 3'd2,
      A_CNTL = 3'd3,
      A_CNTH = 3'd4,
      A_CCFG = 3'd5,
      A_CMPL = 3'd6,
      A_CMPH = 3'd7
   } reg_addr_e;

   localparam int GCTL_RUN = 0;
   localparam int GCTL_LEG = 1;

   typedef struct packed {
      logic m32;
      logic setval;
      logic per;
      logic ien;
   } chcfg_t;
endpackage

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (run) count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/evt_cmp_channel.sv
`timescale 1ns/1ps
module evt_cmp_channel #(
   parameter int CNT_W = 64,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] count,
   input  logic             per_mode,
   input  logic             m32,
   input  logic             wr_cfg,
   input  logic             set_req,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [DW-1:0]    wdata,
   output logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] period,
   output logic             setval,
   output logic             match
);
   localparam int HI_W = CNT_W - DW;

   logic [CNT_W-1:0] cmp_new, per_new, cmp_adv;
   logic             hit, cmp_wr, per_next;

   generate
      if (HI_W > 0) begin : g_wide
         always_comb begin
            cmp_new = cmp;
            per_new = period;
            if (wr_lo) begin
               cmp_new[DW-1:0] = wdata;
               per_new[DW-1:0] = wdata;
            end
            if (wr_hi) begin
               cmp_new[CNT_W-1:DW] = wdata[HI_W-1:0];
               per_new[CNT_W-1:DW] = wdata[HI_W-1:0];
            end
         end
         assign hit     = m32 ? (count[DW-1:0] == cmp[DW-1:0]) : (count == cmp);
         assign cmp_adv = m32 ? {cmp[CNT_W-1:DW], cmp[DW-1:0] + period[DW-1:0]}
                              : cmp + period;
      end else begin : g_narrow
         always_comb begin
            cmp_new = cmp;
            per_new = period;
            if (wr_lo) begin
               cmp_new = wdata;
               per_new = wdata;
            end
         end
         assign hit     = (count == cmp);
         assign cmp_adv = cmp + period;
      end
   endgenerate

   assign cmp_wr = wr_lo | wr_hi;
   assign match  = run & hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp      <= '0;
         period   <= '0;
         setval   <= 1'b0;
         per_next <= 1'b0;
      end else begin
         if (wr_cfg) begin
            setval   <= set_req;
            per_next <= 1'b0;
         end
         if (cmp_wr) begin
            setval <= 1'b0;
            if (per_next) begin
               period   <= per_new;
               per_next <= 1'b0;
            end else if (setval && per_mode) begin
               cmp      <= cmp_new;
               per_next <= 1'b1;
            end else begin
               cmp    <= cmp_new;
               period <= per_new;
            end
         end else if (match && per_mode) begin
            cmp <= cmp_adv;
         end
      end
   end
endmodule

// File: rtl/evt_irq_route.sv
`timescale 1ns/1ps
module evt_irq_route #(
   parameter bit LEG_CAP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic ien,
   input  logic sts_clr,
   input  logic leg_req,
   output logic sts,
   output logic leg_on,
   output logic irq_chan,
   output logic irq_legacy
);
   generate
      if (LEG_CAP) begin : g_leg
         assign leg_on = leg_req;
      end else begin : g_noleg
         logic unused_leg;
         assign unused_leg = leg_req;
         assign leg_on     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)            sts <= 1'b0;
      else if (match && ien) sts <= 1'b1;
      else if (sts_clr)      sts <= 1'b0;
   end

   assign irq_chan   = sts & ~leg_on;
   assign irq_legacy = sts &  leg_on;
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
   import evt_pkg::*;
#(
   parameter int CNT_W   = 64,
   parameter bit LEG_CAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_chan,
   output logic              irq_legacy
);
   generate
      if (CNT_W < BUS_W || CNT_W > 2*BUS_W) begin : g_bad_width
         $error("evt_timer: CNT_W must lie between BUS_W and 2*BUS_W");
      end
   endgenerate

   logic [CNT_W-1:0] count, cmp, period;
   logic             run_q, leg_q, ien_q, per_q, m32_q;
   logic             setval, match, sts, leg_on;
   logic             wr_gctl, wr_gsts, wr_ccfg, wr_cmpl, wr_cmph;
   chcfg_t           cfg_w;

   assign cfg_w   = chcfg_t'(bus_wdata[3:0]);
   assign wr_gctl = bus_wr && (bus_addr == A_GCTL);
   assign wr_gsts = bus_wr && (bus_addr == A_GSTS);
   assign wr_ccfg = bus_wr && (bus_addr == A_CCFG);
   assign wr_cmpl = bus_wr && (bus_addr == A_CMPL);
   assign wr_cmph = bus_wr && (bus_addr == A_CMPH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         leg_q <= 1'b0;
         ien_q <= 1'b0;
         per_q <= 1'b0;
         m32_q <= 1'b0;
      end else begin
         if (wr_gctl) begin
            run_q <= bus_wdata[GCTL_RUN];
            leg_q <= bus_wdata[GCTL_LEG];
         end
         if (wr_ccfg) begin
            ien_q <= cfg_w.ien;
            per_q <= cfg_w.per;
            m32_q <= cfg_w.m32;
         end
      end
   end

   evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .count (count)
   );

   evt_cmp_channel #(.CNT_W(CNT_W), .DW(BUS_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .count    (count),
      .per_mode (per_q),
      .m32      (m32_q),
      .wr_cfg   (wr_ccfg),
      .set_req  (cfg_w.setval),
      .wr_lo    (wr_cmpl),
      .wr_hi    (wr_cmph),
      .wdata    (bus_wdata),
      .cmp      (cmp),
      .period   (period),
      .setval   (setval),
      .match    (match)
   );

   evt_irq_route #(.LEG_CAP(LEG_CAP)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .match      (match),
      .ien        (ien_q),
      .sts_clr    (wr_gsts && bus_wdata[0]),
      .leg_req    (leg_q),
      .sts        (sts),
      .leg_on     (leg_on),
      .irq_chan   (irq_chan),
      .irq_legacy (irq_legacy)
   );

   always_comb begin
      unique case (bus_addr)
         A_CAPS:  bus_rdata = {16'h0, 8'(CNT_W), 7'h0, LEG_CAP};
         A_GCTL:  bus_rdata = {30'h0, leg_on, run_q};
         A_GSTS:  bus_rdata = {31'h0, sts};
         A_CNTL:  bus_rdata = count[BUS_W-1:0];
         A_CNTH:  bus_rdata = BUS_W'(count >> BUS_W);
         A_CCFG:  bus_rdata = {28'h0, m32_q, setval, per_q, ien_q};
         A_CMPL:  bus_rdata = cmp[BUS_W-1:0];
         A_CMPH:  bus_rdata = BUS_W'(cmp >> BUS_W);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
   import evt_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              irq_chan,
   input logic              irq_legacy,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  cmp,
   input logic [CNT_W-1:0]  period,
   input logic              run_q,
   input logic              ien_q,
   input logic              per_q,
   input logic              m32_q,
   input logic              setval,
   input logic              match
);
   logic cmp_wr, irq_any;
   assign cmp_wr  = bus_wr && (bus_addr == 3'd6 || bus_addr == 3'd7);
   assign irq_any = irq_chan || irq_legacy;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> count == $past(count) + CNT_W'(1));                        // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> count == $past(count));                                    // R3
   AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_chan && irq_legacy));                                           // R11
   AST_NO_IRQ_WO_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_q && !irq_any) |=> !irq_any);                                   // R10
   AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (match && ien_q) |=> irq_any);                                        // R10
   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_q && !cmp_wr) |=> cmp == $past(cmp));                           // R9
   AST_PER_ADV_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (match && per_q && !m32_q && !cmp_wr) |=> cmp == $past(cmp) + $past(period)); // R6
   AST_PER_ADV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (match && per_q && m32_q && !cmp_wr) |=>
      cmp[31:0] == $past(cmp[31:0]) + $past(period[31:0]));                // R6
   AST_SETVAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (setval && cmp_wr) |=> !setval);                                      // R8
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .irq_chan   (irq_chan),
   .irq_legacy (irq_legacy),
   .count      (count),
   .cmp        (cmp),
   .period     (period),
   .run_q      (run_q),
   .ien_q      (ien_q),
   .per_q      (per_q),
   .m32_q      (m32_q),
   .setval     (setval),
   .match      (match)
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq_chan, irq_legacy;

   always #2.5 clk = ~clk;

   evt_timer u_evt_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_chan(irq_chan), .irq_legacy(irq_legacy)
   );

   typedef struct { int unsigned when; bit leg; } exp_t;
   exp_t        expq[$];
   int unsigned cyc = 0;
   int          nchk = 0, nfail = 0;
   bit          done = 1'b0;
   logic [1:0]  prv = 2'b00;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d, output int unsigned e);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      e = cyc;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      int unsigned e;
      bus_write(a, d, e);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] expv,
                         input string req, input string what);
      logic [31:0] d;
      rd(a, d);
      check(d == expv, req, what, d, expv);
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(irq_chan || irq_legacy) && n < 3000);
      check(n < 3000, req, "interrupt arrived", n, 0);
   endtask

   task automatic halt(input logic [31:0] gctl, output logic [31:0] c);
      wr(3'd1, gctl);
      rd(3'd3, c);
   endtask

   // scoreboard monitor: every interrupt rise is matched against the queue
   always @(negedge clk) begin
      logic [1:0] now;
      now = {irq_legacy, irq_chan};
      if (rst_n && ((now & ~prv) != 2'b00)) begin
         if (expq.size() == 0) begin
            check(1'b0, "R10", "unexpected interrupt (R9 one-shot)", cyc, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(cyc == e.when, "R5", "interrupt cycle", cyc, e.when);
            check((now & ~prv) == (e.leg ? 2'b10 : 2'b01), "R11", "interrupt line",
                  now, e.leg ? 2 : 1);
         end
      end
      prv = now;
   end

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R12 watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int unsigned e, h;
      logic [31:0] c, c2, d;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R2 capability word
      for (int a = 1; a < 8; a++) rd_chk(3'(a), 32'h0, "R1", "reset register");
      check(!irq_chan && !irq_legacy, "R1", "irq lines at reset", {irq_legacy, irq_chan}, 0);
      rd_chk(3'd0, 32'h0000_4001, "R2", "capability word");
      wr(3'd0, 32'hFFFF_FFFF);
      rd_chk(3'd0, 32'h0000_4001, "R2", "capability after write");

      // R3 counter runs one per clock, R12 write timing
      bus_write(3'd1, 32'h1, e);
      repeat (9) @(negedge clk);
      bus_write(3'd1, 32'h0, h);
      rd_chk(3'd3, h - e, "R3", "counter after run window (R12)");
      rd_chk(3'd4, 32'h0, "R3", "counter high word");
      repeat (5) @(negedge clk);
      rd_chk(3'd3, h - e, "R3", "counter held while halted");
      c = h - e;

      // R9 one-shot, R4 config readback, R10 status clear
      wr(3'd5, 32'h1);
      rd_chk(3'd5, 32'h1, "R4", "config readback");
      wr(3'd6, c + 20);
      wr(3'd7, 32'h0);
      bus_write(3'd1, 32'h1, e);
      expq.push_back('{e + 21, 1'b0});
      wait_irq("R5");
      rd_chk(3'd2, 32'h1, "R10", "status set");
      repeat (30) @(negedge clk);
      rd_chk(3'd6, c + 20, "R9", "one-shot comparator unchanged");
      wr(3'd2, 32'h0);
      rd_chk(3'd2, 32'h1, "R10", "write 0 leaves status");
      wr(3'd2, 32'h1);
      rd_chk(3'd2, 32'h0, "R10", "write 1 clears status");
      halt(32'h0, c);

      // R8 set-value sequence in periodic 32-bit mode
      wr(3'd5, 32'hF);
      rd_chk(3'd5, 32'hF, "R4", "set-value visible before write");
      wr(3'd6, c + 15);
      rd_chk(3'd5, 32'hB, "R8", "set-value self-cleared");
      wr(3'd6, 32'd12);
      rd_chk(3'd6, c + 15, "R8", "second write reached period only");
      bus_write(3'd1, 32'h1, e);
      for (int k = 0; k < 4; k++) expq.push_back('{e + 16 + 12 * k, 1'b0});
      for (int k = 0; k < 4; k++) begin
         wait_irq("R6");
         wr(3'd2, 32'h1);
      end
      halt(32'h0, c2);
      rd_chk(3'd6, c + 15 + 48, "R6", "comparator after four periods");
      c = c2;

      // R7 plain write loads comparator and period
      wr(3'd5, 32'hB);
      wr(3'd6, c + 10);
      rd_chk(3'd6, c + 10, "R7", "comparator loaded");
      bus_write(3'd1, 32'h1, e);
      expq.push_back('{e + 11, 1'b0});
      expq.push_back('{e + 21 + c, 1'b0});
      for (int k = 0; k < 2; k++) begin
         wait_irq("R7");
         wr(3'd2, 32'h1);
      end
      halt(32'h0, c2);
      rd_chk(3'd6, 3 * c + 30, "R7", "period equals written value");
      c = c2;

      // R10 no interrupt while disabled; R6 full-width add still runs
      wr(3'd5, 32'h2);
      wr(3'd6, c + 5);
      wr(3'd1, 32'h1);
      repeat (20) @(negedge clk);
      halt(32'h0, c2);
      rd_chk(3'd2, 32'h0, "R10", "no status with enable clear");
      rd_chk(3'd6, 2 * c + 10, "R6", "full-width advance without enable");
      c = c2;

      // R11 legacy routing
      wr(3'd5, 32'h1);
      wr(3'd6, c + 8);
      bus_write(3'd1, 32'h3, e);
      expq.push_back('{e + 9, 1'b1});
      wait_irq("R11");
      check(irq_legacy && !irq_chan, "R11", "legacy line only", {irq_legacy, irq_chan}, 2);
      rd_chk(3'd1, 32'h3, "R11", "legacy bit readback");
      wr(3'd2, 32'h1);
      halt(32'h0, c);

      // R5 full-width compare ignores low-word equality when high differs
      wr(3'd7, 32'h1);
      wr(3'd6, c + 6);
      wr(3'd1, 32'h1);
      repeat (20) @(negedge clk);
      halt(32'h0, c2);
      rd_chk(3'd2, 32'h0, "R5", "no match with high word different");
      wr(3'd5, 32'h9);
      wr(3'd6, c2 + 6);
      bus_write(3'd1, 32'h1, e);
      expq.push_back('{e + 7, 1'b0});
      wait_irq("R5");
      wr(3'd2, 32'h1);
      halt(32'h0, c);

      // R6 low-word wrap in 32-bit periodic mode
      wr(3'd5, 32'h0);
      wr(3'd7, 32'h7);
      wr(3'd5, 32'hF);
      wr(3'd6, c + 5);
      wr(3'd6, 32'hFFFF_FFFF);
      bus_write(3'd1, 32'h1, e);
      expq.push_back('{e + 6, 1'b0});
      wait_irq("R6");
      wr(3'd2, 32'h1);
      halt(32'h0, c2);
      rd_chk(3'd6, c + 4, "R6", "low word wrapped");
      rd_chk(3'd7, 32'h7, "R6", "high word unchanged");

      repeat (5) @(negedge clk);
      check(expq.size() == 0, "R5", "all expected interrupts seen", expq.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule